// File: doc/BRIEF.md
# LED Channel Fault Detection Controller

This block decides, for each of sixteen constant-current LED channels, whether the channel is healthy or has an open or shorted load. It does this from comparator flags produced by analog circuits outside the block. The result is a fault word with one bit per channel. When a result is ready, the block raises a load request so that the serial shift register copies the word in on its next shift pulse. The data input is ignored on that pulse.

There are two ways to run a check:
- **Automatic:** a check starts when the active-low output enable falls, meaning the outputs turn on. The flags of the channels that are switched on are sampled once, at the end of a fixed window. If the outputs turn off before the window ends, the result is invalid and every bit reads normal.
- **Manual:** a manual command, given while the outputs are forced off, raises a test-current strobe to all channels for the same window length. It then captures every channel.

The enable input and the flags are synchronised by two flops inside the block. The window length is a parameter: 80 cycles gives 800 ns at a 100 MHz clock.

Top module: `led_fault_detect`

## Requirements
- R1: After reset, `fault_word` is all ones, and `load_req` and `test_drive` are 0.
- R2: Bit i of `fault_word` belongs to channel i and is 0 for a fault and 1 for normal. An open flag counts as a fault only while `open_det_en` is 1, and a short flag only while `short_det_en` is 1. When both are enabled, either flag gives 0.
- R3: Automatic detection starts only on a high-to-low transition of `enable_n`. If `enable_n` is held low from reset, the word never changes.
- R4: If `enable_n` stays low for WIN_CYCLES cycles after the detected fall, the word is captured. Channels whose `chan_on` bit is 0 read 1.
- R5: If `enable_n` returns high before the window completes, the automatic result is invalid and the word becomes all ones.
- R6: A `manual_cmd` pulse taken while `enable_n` is high and at least one detection enable is set raises `test_drive` for exactly WIN_CYCLES cycles. The block then captures all channels regardless of `chan_on` and sets `load_req`.
- R7: A `manual_cmd` pulse while `enable_n` is low, or while both detection enables are 0, is ignored. No strobe appears, no load is requested and the word is unchanged.
- R8: An `onoff_cmd` pulse sets `load_req` when any detection enable is 1, and does nothing otherwise. A `shift_tick` pulse clears `load_req`.
- R9: The flags are sampled once, at the end of the window. Later flag changes do not alter the held word.
- R10: With both detection enables at 0, a fall of `enable_n` leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset |
| enable_n | input | 1 | Active-low output enable (high forces outputs off) |
| chan_on | input | NCH | On/off register contents, one bit per channel |
| open_flag | input | NCH | Per-channel open comparator flags |
| short_flag | input | NCH | Per-channel short comparator flags |
| open_det_en | input | 1 | Open detection enable |
| short_det_en | input | 1 | Short detection enable |
| onoff_cmd | input | 1 | One-cycle pulse: on/off data was loaded |
| manual_cmd | input | 1 | One-cycle pulse: manual test command |
| shift_tick | input | 1 | One-cycle pulse: first shift pulse took the word |
| fault_word | output | NCH | Held fault result, 0 = fault, 1 = normal |
| load_req | output | 1 | Request to parallel-load the fault word |
| test_drive | output | 1 | Test-current strobe for the manual test |

## Verification
A counter that stops early or late shows at the ports as a `test_drive` pulse of the wrong length. The bench sees this when the strobe falls, WIN_CYCLES cycles after the command. It also shows as a short automatic window being treated as valid, which leaves a captured fault pattern where all ones belong, visible one cycle after the window would end. A wrong gating of flags by enables or `chan_on` appears in the very next word captured. A stale sequencer state appears as a spurious strobe, or as a word that changes with no command or enable edge; the bench watches for both after each stimulus.

// File: rtl/led_fault_detect.sv
module led_fault_detect #(
  parameter int NCH        = 16,
  parameter int WIN_CYCLES = 80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable_n,
  input  logic [NCH-1:0] chan_on,
  input  logic [NCH-1:0] open_flag,
  input  logic [NCH-1:0] short_flag,
  input  logic           open_det_en,
  input  logic           short_det_en,
  input  logic           onoff_cmd,
  input  logic           manual_cmd,
  input  logic           shift_tick,
  output logic [NCH-1:0] fault_word,
  output logic           load_req,
  output logic           test_drive
);

  localparam int CW = $clog2(WIN_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_AUTO, ST_MANUAL} st_t;

  st_t            st;
  logic [2:0]     en_pipe;
  logic [NCH-1:0] open_m, open_s, short_m, short_s;
  logic [CW-1:0]  win_cnt;

  logic           det_on, en_lvl, en_fall, win_last, busy, load_set;
  logic [NCH-1:0] hit;

  assign det_on   = open_det_en | short_det_en;
  assign en_lvl   = en_pipe[1];
  assign en_fall  = en_pipe[2] & ~en_pipe[1];
  assign win_last = (win_cnt == CW'(WIN_CYCLES - 1));
  assign busy     = (st != ST_IDLE);
  assign hit      = (open_det_en ? open_s : '0) | (short_det_en ? short_s : '0);
  assign load_set = (onoff_cmd && det_on) || (st == ST_MANUAL && win_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_pipe <= '0;
      open_m  <= '0;
      open_s  <= '0;
      short_m <= '0;
      short_s <= '0;
    end else begin
      en_pipe <= {en_pipe[1:0], enable_n};
      open_m  <= open_flag;
      open_s  <= open_m;
      short_m <= short_flag;
      short_s <= short_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      win_cnt    <= '0;
      test_drive <= 1'b0;
      fault_word <= '1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (manual_cmd && det_on && en_lvl) begin
            st         <= ST_MANUAL;
            win_cnt    <= '0;
            test_drive <= 1'b1;
          end else if (en_fall && det_on) begin
            st      <= ST_AUTO;
            win_cnt <= '0;
          end
        end
        ST_AUTO: begin
          if (en_lvl) begin
            fault_word <= '1;
            st         <= ST_IDLE;
          end else if (win_last) begin
            fault_word <= ~(hit & chan_on);
            st         <= ST_IDLE;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_MANUAL: begin
          if (win_last) begin
            fault_word <= ~hit;
            test_drive <= 1'b0;
            st         <= ST_IDLE;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          load_req <= 1'b0;
    else if (load_set)   load_req <= 1'b1;
    else if (shift_tick) load_req <= 1'b0;
  end

endmodule

// File: rtl/led_fault_detect_chk.sv
module led_fault_detect_chk #(
  parameter int NCH        = 16,
  parameter int WIN_CYCLES = 80,
  parameter int CW         = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           manual_cmd,
  input logic           onoff_cmd,
  input logic           shift_tick,
  input logic           test_drive,
  input logic           load_req,
  input logic [NCH-1:0] fault_word,
  input logic           busy,
  input logic [CW-1:0]  win_cnt
);

  assert_strobe_from_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_drive) |-> $past(manual_cmd));

  assert_strobe_end_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_drive) |-> load_req);

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (win_cnt < CW'(WIN_CYCLES)));

  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_word) |-> $past(busy));

  assert_load_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_req) |-> ($past(onoff_cmd) || $past(test_drive)));

  assert_load_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_tick && !onoff_cmd && !test_drive) |=> !load_req);

endmodule

bind led_fault_detect led_fault_detect_chk #(
  .NCH(NCH), .WIN_CYCLES(WIN_CYCLES), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .manual_cmd(manual_cmd), .onoff_cmd(onoff_cmd),
  .shift_tick(shift_tick), .test_drive(test_drive), .load_req(load_req),
  .fault_word(fault_word), .busy(busy), .win_cnt(win_cnt)
);

// File: tb/led_fault_detect_test.sv
module led_fault_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int WIN = 80;

  // {open_en, short_en, open_flag, short_flag, expected word}
  localparam logic [49:0] VECS [5] = '{
    {1'b1, 1'b0, 16'h00F0, 16'h0F00, 16'hFF0F},
    {1'b0, 1'b1, 16'h00F0, 16'h0F00, 16'hF0FF},
    {1'b1, 1'b1, 16'hA5A5, 16'h5A5A, 16'h0000},
    {1'b1, 1'b1, 16'h0000, 16'h0000, 16'hFFFF},
    {1'b1, 1'b1, 16'h8001, 16'h0010, 16'h7FEE}
  };

  logic clk = 0, rst_n = 0, enable_n = 0;
  logic [NCH-1:0] chan_on = '1, open_flag = '1, short_flag = '0;
  logic open_det_en = 1, short_det_en = 0;
  logic onoff_cmd = 0, manual_cmd = 0, shift_tick = 0;
  logic [NCH-1:0] fault_word;
  logic load_req, test_drive;
  int total = 0, bad = 0;
  bit finished = 0;

  led_fault_detect #(.NCH(NCH), .WIN_CYCLES(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .enable_n(enable_n), .chan_on(chan_on),
    .open_flag(open_flag), .short_flag(short_flag), .open_det_en(open_det_en),
    .short_det_en(short_det_en), .onoff_cmd(onoff_cmd), .manual_cmd(manual_cmd),
    .shift_tick(shift_tick), .fault_word(fault_word), .load_req(load_req),
    .test_drive(test_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_manual(output int n);
    @(negedge clk) manual_cmd = 1;
    @(negedge clk) manual_cmd = 0;
    n = 0;
    while (test_drive && n < 4 * WIN) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1;
    @(negedge clk) sig = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 word", 32'(fault_word), 32'hFFFF);
    check("R1 load_req", 32'(load_req), 0);
    check("R1 test_drive", 32'(test_drive), 0);
    wait_cyc(WIN + 30);
    check("R3 held low, no window", 32'(fault_word), 32'hFFFF);

    enable_n = 1;
    wait_cyc(5);
    foreach (VECS[k]) begin
      {open_det_en, short_det_en, open_flag, short_flag} = VECS[k][49:16];
      wait_cyc(4);
      pulse_manual(n);
      check("R6 strobe length", 32'(n), 32'(WIN));
      check("R2 manual word", 32'(fault_word), 32'(VECS[k][15:0]));
      check("R6 load_req set", 32'(load_req), 1);
      pulse(shift_tick);
      check("R8 shift clears load_req", 32'(load_req), 0);
    end

    pulse(onoff_cmd);
    check("R8 onoff sets load_req", 32'(load_req), 1);
    pulse(shift_tick);
    open_det_en = 0; short_det_en = 0;
    pulse(onoff_cmd);
    check("R8 onoff ignored when off", 32'(load_req), 0);

    open_flag = '1; short_flag = '1;
    enable_n = 0;
    wait_cyc(WIN + 20);
    check("R10 disabled fall", 32'(fault_word), 32'h7FEE);

    open_det_en = 1; short_det_en = 1;
    wait_cyc(4);
    pulse(manual_cmd);
    wait_cyc(3);
    check("R7 manual while on: strobe", 32'(test_drive), 0);
    check("R7 manual while on: load", 32'(load_req), 0);
    check("R7 manual while on: word", 32'(fault_word), 32'h7FEE);

    enable_n = 1;
    chan_on = 16'h00FF; open_flag = 16'h0003; short_flag = 16'h0300;
    wait_cyc(5);
    enable_n = 0;
    wait_cyc(WIN + 20);
    check("R4 auto word, off channels normal", 32'(fault_word), 32'hFFFC);

    open_flag = '1; short_flag = '1;
    wait_cyc(20);
    check("R9 word held", 32'(fault_word), 32'hFFFC);

    enable_n = 1;
    wait_cyc(5);
    enable_n = 0;
    wait_cyc(30);
    enable_n = 1;
    wait_cyc(10);
    check("R5 short window invalid", 32'(fault_word), 32'hFFFF);

    enable_n = 0;
    wait_cyc(WIN + 20);
    check("R4 full window", 32'(fault_word), 32'hFF00);

    enable_n = 1;
    open_det_en = 0; short_det_en = 0;
    wait_cyc(5);
    pulse(manual_cmd);
    wait_cyc(3);
    check("R7 manual while disabled: strobe", 32'(test_drive), 0);
    check("R7 manual while disabled: word", 32'(fault_word), 32'hFF00);

    finish_run();
  end
endmodule